// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block watches the running clock-calendar and decides, once per time update, whether the programmed alarm has come due. It holds five alarm bytes (second, minute, hour, day of month, month) that software loads through a small write port. On every update tick it compares each alarm byte with the matching current-time byte, treating any alarm byte whose two top bits are both set as "don't care". When every field agrees it emits a one-cycle match pulse and sets a sticky alarm flag, which stays set until a status read clears it.

The comparison is a plain byte equality, so it works the same whether the calendar runs in BCD or binary, as long as the alarm bytes use the same format as the time bytes. The format select is used for one thing only: a day or month alarm byte that is not a wildcard and lies outside the legal range for the selected format can never match. The flag, gated by an enable, drives the alarm interrupt output. The century byte of the calendar plays no role here.

Top module: `alarm_match_top`

## Requirements
- R1: An alarm byte whose bits 7 and 6 are both 1 is a wildcard and matches any current value of its field.
- R2: The comparison is made only in a cycle where `tick` is 1; `match_pulse` is 1 for exactly the one cycle after that clock edge and is 0 whenever the edge before had `tick` at 0.
- R3: A match needs every non-wildcard field to equal its current byte bit for bit; a single differing field suppresses the pulse.
- R4: After reset the day and month alarm bytes hold 0xC0 (wildcard), the second, minute and hour alarm bytes hold 0x00, and `alarm_flag` is 0.
- R5: `alarm_flag` is set at the edge that produces a match pulse and holds until an edge with `flag_rd` at 1; if a match and a read coincide the flag stays set.
- R6: A write with `wr_en` at 1 loads `wr_data` into the alarm byte picked by `wr_sel`: 0 second, 1 minute, 2 hour, 3 day, 4 month; codes 5 to 7 change no alarm byte.
- R7: `alarm_irq` is 1 exactly when `alarm_flag` is 1 and `irq_en` is 1.
- R8: A non-wildcard day or month alarm byte outside its legal range never matches. With `bin_mode` 0 (BCD) the day range is 0x01 to 0x31 and the month range 0x01 to 0x12, each with a low nibble of 9 or less; with `bin_mode` 1 the day range is 0x01 to 0x1F and the month range 0x01 to 0x0C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Marks the cycle in which the time bytes are freshly updated |
| bin_mode | input | 1 | 1 binary calendar format, 0 BCD format |
| cur_sec | input | 8 | Current seconds |
| cur_min | input | 8 | Current minutes |
| cur_hour | input | 8 | Current hours |
| cur_day | input | 8 | Current day of month |
| cur_mon | input | 8 | Current month |
| wr_en | input | 1 | Alarm byte write strobe |
| wr_sel | input | 3 | Alarm byte select |
| wr_data | input | 8 | Alarm byte write value |
| flag_rd | input | 1 | Status read, clears the alarm flag |
| irq_en | input | 1 | Alarm interrupt enable |
| match_pulse | output | 1 | One-cycle pulse on a full match |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
A corrupted alarm byte or a wrong range decision shows up on the very next tick as a missing or extra `match_pulse`, one cycle after the tick edge, so the bench sweeps every one of the 256 day and month alarm codes in both formats against an equal and a differing current value. A wrong flag state is visible one cycle later on `alarm_flag` and `alarm_irq`, and a stuck flag appears at the first read that fails to clear it. Reset defaults are seen through the first tick, where day and month must behave as wildcards.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;

    localparam int BYTE_W      = 8;
    localparam int FIELD_COUNT = 5;
    localparam int SEL_W       = 3;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [SEL_W-1:0] {
        FLD_SEC  = 3'd0,
        FLD_MIN  = 3'd1,
        FLD_HOUR = 3'd2,
        FLD_DAY  = 3'd3,
        FLD_MON  = 3'd4
    } field_e;

    // Range check applied to a field: none, day-of-month, month.
    typedef enum logic [1:0] {
        RANGE_NONE = 2'd0,
        RANGE_DAY  = 2'd1,
        RANGE_MON  = 2'd2
    } range_e;

    typedef struct packed {
        logic match;
        logic flag;
    } flag_state_t;

    function automatic logic is_wild(input byte_t v);
        return v[BYTE_W-1] & v[BYTE_W-2];
    endfunction

    function automatic logic in_range(input byte_t v, input logic bin,
                                      input byte_t bcd_max, input byte_t bin_max);
        if (bin)
            return (v != '0) && (v <= bin_max);
        else
            return (v != '0) && (v <= bcd_max) && (v[3:0] <= 4'd9);
    endfunction

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import alarm_match_pkg::*;
#(
    parameter int NUM_FIELDS = FIELD_COUNT,
    parameter logic [NUM_FIELDS-1:0] WILD_RESET_MASK = 5'b11000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_sel,
    input  byte_t                     wr_data,
    output byte_t [NUM_FIELDS-1:0]    alarm_q
);
    localparam byte_t WILD_CODE = {2'b11, {(BYTE_W-2){1'b0}}};

    byte_t [NUM_FIELDS-1:0] alarm_d;

    always_comb begin
        alarm_d = alarm_q;
        if (wr_en && (int'(wr_sel) < NUM_FIELDS))
            alarm_d[wr_sel] = wr_data;
    end

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_reg
        localparam byte_t RST_VAL = WILD_RESET_MASK[f] ? WILD_CODE : '0;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) alarm_q[f] <= RST_VAL;
            else        alarm_q[f] <= alarm_d[f];
        end
    end

    // Without a write strobe no alarm byte may move.
    assert_hold_without_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) && $past(rst_n) |-> $stable(alarm_q));

endmodule

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
    import alarm_match_pkg::*;
#(
    parameter range_e RANGE    = RANGE_NONE,
    parameter byte_t  BCD_MAX  = 8'hFF,
    parameter byte_t  BIN_MAX  = 8'hFF
) (
    input  byte_t alarm_val,
    input  byte_t cur_val,
    input  logic  bin_mode,
    output logic  hit
);
    logic wild;
    logic legal;

    always_comb begin
        wild = is_wild(alarm_val);
        if (RANGE == RANGE_NONE) legal = 1'b1;
        else                     legal = in_range(alarm_val, bin_mode, BCD_MAX, BIN_MAX);
        hit = wild || (legal && (alarm_val == cur_val));
    end

endmodule

// File: rtl/alarm_match_top.sv
module alarm_match_top
    import alarm_match_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       bin_mode,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_hour,
    input  logic [7:0] cur_day,
    input  logic [7:0] cur_mon,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       flag_rd,
    input  logic       irq_en,
    output logic       match_pulse,
    output logic       alarm_flag,
    output logic       alarm_irq
);
    byte_t [FIELD_COUNT-1:0] alarm_q;
    byte_t [FIELD_COUNT-1:0] cur_vec;
    logic  [FIELD_COUNT-1:0] hits;
    flag_state_t             st_d, st_q;
    logic                    all_hit;

    assign cur_vec[FLD_SEC]  = cur_sec;
    assign cur_vec[FLD_MIN]  = cur_min;
    assign cur_vec[FLD_HOUR] = cur_hour;
    assign cur_vec[FLD_DAY]  = cur_day;
    assign cur_vec[FLD_MON]  = cur_mon;

    alarm_regs #(
        .NUM_FIELDS      (FIELD_COUNT),
        .WILD_RESET_MASK (5'b11000)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .alarm_q (alarm_q)
    );

    for (genvar f = 0; f < FIELD_COUNT; f++) begin : g_cmp
        localparam range_e KIND = (f == FLD_DAY) ? RANGE_DAY :
                                  (f == FLD_MON) ? RANGE_MON : RANGE_NONE;
        localparam byte_t  BCD_LIM = (f == FLD_DAY) ? 8'h31 : (f == FLD_MON) ? 8'h12 : 8'hFF;
        localparam byte_t  BIN_LIM = (f == FLD_DAY) ? 8'h1F : (f == FLD_MON) ? 8'h0C : 8'hFF;
        alarm_field_cmp #(
            .RANGE   (KIND),
            .BCD_MAX (BCD_LIM),
            .BIN_MAX (BIN_LIM)
        ) u_cmp (
            .alarm_val (alarm_q[f]),
            .cur_val   (cur_vec[f]),
            .bin_mode  (bin_mode),
            .hit       (hits[f])
        );
    end

    assign all_hit = &hits;

    always_comb begin
        st_d       = st_q;
        st_d.match = tick && all_hit;
        if (st_d.match)   st_d.flag = 1'b1;
        else if (flag_rd) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign match_pulse = st_q.match;
    assign alarm_flag  = st_q.flag;
    assign alarm_irq   = st_q.flag && irq_en;

    assert_pulse_only_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> $past(tick));

    assert_full_match_fires_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick && all_hit |=> match_pulse);

    assert_pulse_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> alarm_flag);

    assert_flag_drops_only_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_flag) |-> $past(flag_rd));

    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> alarm_flag);

endmodule

// File: tb/test_alarm_match_top.sv
module test_alarm_match_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, bin_mode = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_day = 8'h01, cur_mon = 8'h01;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       flag_rd = 1'b0, irq_en = 1'b0;
    logic       match_pulse, alarm_flag, alarm_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    alarm_match_top i_alarm_match_top (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bin_mode(bin_mode),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_day(cur_day), .cur_mon(cur_mon),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .flag_rd(flag_rd), .irq_en(irq_en),
        .match_pulse(match_pulse), .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic write_alarm(input logic [2:0] sel, input logic [7:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Tick once, then compare the pulse and flag one cycle later, then clear.
    task automatic tick_check(input string req, input logic exp);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check(req, match_pulse, exp);
        check(req, alarm_flag, exp);
        flag_rd = 1'b1;
        @(negedge clk);
        flag_rd = 1'b0;
    endtask

    function automatic logic legal_exp(input logic [7:0] a, input logic bin, input int lim);
        int hi = int'(a) / 16;
        int lo = int'(a) % 16;
        if (bin) return (int'(a) >= 1) && (int'(a) <= lim);
        return (lo <= 9) && (hi * 10 + lo >= 1) && (hi * 10 + lo <= lim);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R4: reset state
        check("R4 flag after reset", alarm_flag, 1'b0);
        check("R4 pulse after reset", match_pulse, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: sec/min/hour zero, day/month wildcard
        cur_day = 8'h17; cur_mon = 8'h09;
        tick_check("R4 reset alarm defaults", 1'b1);
        cur_sec = 8'h01;
        tick_check("R4 second default is 00", 1'b0);
        cur_sec = 8'h00;

        // R2: no tick, no pulse
        @(negedge clk);
        @(negedge clk);
        check("R2 no pulse without tick", match_pulse, 1'b0);
        check("R2 no flag without tick", alarm_flag, 1'b0);

        // R8/R1: sweep every day and month alarm code in both formats
        for (int m = 0; m < 2; m++) begin
            bin_mode = logic'(m);
            for (int fld = 3; fld <= 4; fld++) begin
                for (int a = 0; a < 256; a++) begin
                    logic [7:0] av = 8'(a);
                    logic wild = av[7] & av[6];
                    logic ok = legal_exp(av, bin_mode, (fld == 3) ? 31 : 12);
                    write_alarm(3'(fld), av);
                    if (fld == 3) cur_day = av; else cur_mon = av;
                    tick_check(wild ? "R1 wildcard equal" : "R8 range equal", wild | ok);
                    if (fld == 3) cur_day = av ^ 8'h01; else cur_mon = av ^ 8'h01;
                    tick_check(wild ? "R1 wildcard differs" : "R3 day/month differs", wild);
                end
                write_alarm(3'(fld), 8'hC0);
            end
        end
        bin_mode = 1'b0;

        // R3/R1: seconds, minutes, hours equality sweep
        for (int fld = 0; fld < 3; fld++) begin
            for (int a = 0; a < 256; a += 5) begin
                logic [7:0] av = 8'(a);
                logic wild = av[7] & av[6];
                write_alarm(3'(fld), av);
                case (fld)
                    0: cur_sec = av ^ 8'h10;
                    1: cur_min = av ^ 8'h10;
                    default: cur_hour = av ^ 8'h10;
                endcase
                tick_check(wild ? "R1 wildcard time" : "R3 time field differs", wild);
                case (fld)
                    0: cur_sec = av;
                    1: cur_min = av;
                    default: cur_hour = av;
                endcase
                tick_check("R3 time field equal", 1'b1);
            end
        end

        // R6: set a known alarm, then unused selects must not disturb it
        write_alarm(3'd0, 8'h42); write_alarm(3'd1, 8'h30); write_alarm(3'd2, 8'h07);
        write_alarm(3'd3, 8'h15); write_alarm(3'd4, 8'h06);
        cur_sec = 8'h42; cur_min = 8'h30; cur_hour = 8'h07; cur_day = 8'h15; cur_mon = 8'h06;
        for (int s = 5; s < 8; s++) write_alarm(3'(s), 8'hFF);
        tick_check("R6 unused selects ignored", 1'b1);
        cur_hour = 8'h08;
        tick_check("R6 hour select loads hour", 1'b0);
        cur_hour = 8'h07;

        // R5: flag sticky, read clears, set wins over read
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 flag sticky", alarm_flag, 1'b1);
        check("R5 pulse one cycle", match_pulse, 1'b0);
        // R7: interrupt gating
        check("R7 irq disabled", alarm_irq, 1'b0);
        irq_en = 1'b1; #1;
        check("R7 irq enabled", alarm_irq, 1'b1);
        tick = 1'b1; flag_rd = 1'b1;
        @(negedge clk); tick = 1'b0; flag_rd = 1'b0;
        check("R5 set wins over read", alarm_flag, 1'b1);
        flag_rd = 1'b1;
        @(negedge clk); flag_rd = 1'b0;
        check("R5 read clears", alarm_flag, 1'b0);
        check("R7 irq follows flag", alarm_irq, 1'b0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule